// File: doc/BRIEF.md
# Frame Buffer Rectangle Transfer Engine

This engine moves rectangular blocks of 16-bit pixels between a 32-bit host data port and a frame buffer of 1024 columns by 512 rows. A transfer starts with one pulse that presents a position word and a size word, and a direction bit that selects upload (host to buffer) or download (buffer to host). Every data word then carries two pixels, low half first, which fill the rectangle row by row from left to right.

The frame buffer is a plain synchronous pixel RAM with one port per pixel lane. The engine drives an address, a write enable and write data on each lane, and reads each lane's data one cycle after it issues the address. The column offset, the current row and the count of rows left are all held between words, so the host may pause for any number of cycles, even in the middle of a row. A download raises a ready flag for as long as pixels remain to be read. An upload ends with a one-cycle done strobe that carries the rectangle as it was started. An abort input stops any transfer at once.

Top module: `rect_xfer_engine`

## Requirements
- R1: The start column is position bits 9:0 and the start row is position bits 24:16. The first pixel of a transfer goes to lane address row*1024 + column.
- R2: The width is ((size - 1) AND 0x3FF) + 1, taken from size bits 9:0. A width field of 0 gives 1024 pixels per row.
- R3: The height is (((size >> 16) - 1) AND 0x1FF) + 1, taken from size bits 24:16. A height field of 0 gives 512 rows.
- R4: Bits 15:0 of a data word are the earlier pixel and use lane 0. Bits 31:16 are the next pixel and use lane 1. Pixels advance along a row and then move to the start column of the next row.
- R5: The row index wraps from 511 to 0 as rows advance.
- R6: The column address is (start column + offset) mod 1024, so a row that crosses column 1023 continues at column 0.
- R7: Idle cycles between data words, including in the middle of a row, do not change the pixel sequence. The next word resumes at the saved offset.
- R8: A download sets img_ready_o on the edge that starts it. Each request returns its data on rd_data_o with rd_valid_o exactly one cycle later. img_ready_o clears on the edge that takes the request for the final pixel.
- R9: On the cycle after an upload's final word, done_o is high for one cycle, and done_x_o, done_y_o, done_w_o and done_h_o hold the start column, start row, width and height.
- R10: abort_i clears busy_o and img_ready_o on the next edge and cancels the transfer. After an abort no pixel is written and no done strobe appears.
- R11: Data words and read requests that arrive while no transfer is active have no effect: no write enable, no rd_valid_o.
- R12: When the pixel count is odd, the upper half of the last word is not written (lane 1 write enable stays low). On a download that lane returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Cancels any transfer in progress |
| start_i | input | 1 | Starts a transfer using pos_i and size_i |
| start_rd_i | input | 1 | Direction with start_i: 1 = download, 0 = upload |
| pos_i | input | 32 | Position word (column in 9:0, row in 24:16) |
| size_i | input | 32 | Size word (width in 9:0, height in 24:16) |
| wr_valid_i | input | 1 | Upload data word present |
| wr_data_i | input | 32 | Upload data word, two pixels |
| rd_req_i | input | 1 | Download word request |
| rd_valid_o | output | 1 | Download data valid, one cycle after a request |
| rd_data_o | output | 32 | Download data word |
| mem_we_o | output | 2 | Per-lane pixel write enable |
| mem_addr_o | output | 38 | Per-lane pixel address, 19 bits per lane |
| mem_wdata_o | output | 32 | Per-lane pixel write data |
| mem_rdata_i | input | 32 | Per-lane pixel read data, one cycle after the address |
| busy_o | output | 1 | Transfer active |
| img_ready_o | output | 1 | Download has pixels left to read |
| done_o | output | 1 | One-cycle upload completion strobe |
| done_x_o | output | 10 | Start column of the completed rectangle |
| done_y_o | output | 9 | Start row of the completed rectangle |
| done_w_o | output | 11 | Width of the completed rectangle |
| done_h_o | output | 10 | Height of the completed rectangle |

## Verification
The bench targets the points where a row ends partway through a word, where the column crosses 1023 and the row crosses 511, and where the size fields are zero. A design that got these wrong would write the second pixel of a word to the wrong row, spill past column 1023 into the next row, or treat a zero field as an empty transfer. Pauses of random length between words check that a design which drops its saved offset would restart the row. An odd pixel count checks that the spare upper half of the final word is neither written nor returned as stale data. Aborts during both directions check that a write enable or a done strobe does not leak out afterwards.

// File: rtl/rect_xfer_pkg.sv
package rect_xfer_pkg;
  localparam int unsigned FB_XW    = 10;  // log2 of frame buffer columns
  localparam int unsigned FB_YW    = 9;   // log2 of frame buffer rows
  localparam int unsigned PIX_W    = 16;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned FLD_HI   = 16;  // lsb of the upper field in pos/size
  typedef enum logic {DIR_UPLOAD = 1'b0, DIR_DOWNLOAD = 1'b1} xfer_dir_e;
endpackage

// File: rtl/rect_decode.sv
module rect_decode #(
  parameter int unsigned XW  = rect_xfer_pkg::FB_XW,
  parameter int unsigned YW  = rect_xfer_pkg::FB_YW,
  parameter int unsigned CW  = rect_xfer_pkg::CMD_W,
  parameter int unsigned HI  = rect_xfer_pkg::FLD_HI
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] size_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [XW:0]   w_o,
  output logic [YW:0]   h_o
);
  logic [XW-1:0] w_m1;
  logic [YW-1:0] h_m1;
  logic          unused_bits;

  assign x_o  = pos_i[XW-1:0];
  assign y_o  = pos_i[HI +: YW];
  // minus one then plus one: a zero field means full span
  assign w_m1 = size_i[XW-1:0] - 1'b1;
  assign h_m1 = size_i[HI +: YW] - 1'b1;
  assign w_o  = {1'b0, w_m1} + 1'b1;
  assign h_o  = {1'b0, h_m1} + 1'b1;

  assign unused_bits = ^{pos_i[CW-1:HI+YW], pos_i[HI-1:XW],
                         size_i[CW-1:HI+YW], size_i[HI-1:XW]};
endmodule

// File: rtl/rect_pix_step.sv
module rect_pix_step #(
  parameter int unsigned XW = rect_xfer_pkg::FB_XW,
  parameter int unsigned YW = rect_xfer_pkg::FB_YW,
  localparam int unsigned AW = XW + YW
) (
  input  logic [XW-1:0] base_x_i,
  input  logic [XW:0]   width_i,
  input  logic [XW-1:0] col_i,
  input  logic [YW-1:0] row_i,
  input  logic [YW:0]   left_i,
  output logic          live_o,
  output logic [AW-1:0] addr_o,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic [YW:0]   left_o
);
  logic [XW-1:0] col_abs;
  logic [XW:0]   col_nxt;

  assign live_o  = (left_i != '0);
  assign col_abs = base_x_i + col_i;      // wraps at buffer width
  assign addr_o  = {row_i, col_abs};      // row * 2**XW + column
  assign col_nxt = {1'b0, col_i} + 1'b1;

  always_comb begin
    col_o  = col_i;
    row_o  = row_i;
    left_o = left_i;
    if (live_o) begin
      if (col_nxt >= width_i) begin
        col_o  = '0;
        row_o  = row_i + 1'b1;            // wraps at buffer height
        left_o = left_i - 1'b1;
      end else begin
        col_o  = col_nxt[XW-1:0];
      end
    end
  end
endmodule

// File: rtl/rect_xfer_engine.sv
module rect_xfer_engine #(
  parameter int unsigned PPW = 2,
  parameter int unsigned XW  = rect_xfer_pkg::FB_XW,
  parameter int unsigned YW  = rect_xfer_pkg::FB_YW,
  parameter int unsigned PW  = rect_xfer_pkg::PIX_W,
  parameter int unsigned CW  = rect_xfer_pkg::CMD_W,
  localparam int unsigned AW = XW + YW,
  localparam int unsigned DW = PW * PPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [CW-1:0]     pos_i,
  input  logic [CW-1:0]     size_i,
  input  logic              wr_valid_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DW-1:0]     rd_data_o,
  output logic [PPW-1:0]    mem_we_o,
  output logic [PPW*AW-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o,
  output logic              img_ready_o,
  output logic              done_o,
  output logic [XW-1:0]     done_x_o,
  output logic [YW-1:0]     done_y_o,
  output logic [XW:0]       done_w_o,
  output logic [YW:0]       done_h_o
);
  import rect_xfer_pkg::*;

  logic [XW-1:0] dec_x;
  logic [YW-1:0] dec_y;
  logic [XW:0]   dec_w;
  logic [YW:0]   dec_h;

  xfer_dir_e     dir_q;
  logic          busy_q, rdy_q, done_q, rd_valid_q;
  logic [PPW-1:0] rd_lane_q;
  logic [XW-1:0] x0_q;
  logic [YW-1:0] y0_q;
  logic [XW:0]   w_q;
  logic [YW:0]   h_q;
  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic [YW:0]   left_q;

  logic [XW-1:0] col_c  [PPW+1];
  logic [YW-1:0] row_c  [PPW+1];
  logic [YW:0]   left_c [PPW+1];
  logic [PPW-1:0] live;
  logic          fire, last;

  rect_decode #(.XW(XW), .YW(YW), .CW(CW), .HI(FLD_HI)) u_decode (
    .pos_i (pos_i), .size_i(size_i),
    .x_o   (dec_x), .y_o   (dec_y), .w_o(dec_w), .h_o(dec_h)
  );

  assign fire = busy_q & ((dir_q == DIR_DOWNLOAD) ? rd_req_i : wr_valid_i);

  assign col_c[0]  = col_q;
  assign row_c[0]  = row_q;
  assign left_c[0] = left_q;

  for (genvar k = 0; k < PPW; k++) begin : g_lane
    logic [AW-1:0] lane_addr;
    rect_pix_step #(.XW(XW), .YW(YW)) u_step (
      .base_x_i(x0_q),        .width_i(w_q),
      .col_i   (col_c[k]),    .row_i  (row_c[k]),    .left_i(left_c[k]),
      .live_o  (live[k]),     .addr_o (lane_addr),
      .col_o   (col_c[k+1]),  .row_o  (row_c[k+1]),  .left_o(left_c[k+1])
    );
    assign mem_addr_o[k*AW +: AW]  = lane_addr;
    assign mem_we_o[k]             = fire & (dir_q == DIR_UPLOAD) & live[k];
    assign mem_wdata_o[k*PW +: PW] = wr_data_i[k*PW +: PW];
    assign rd_data_o[k*PW +: PW]   = rd_lane_q[k] ? mem_rdata_i[k*PW +: PW] : '0;
  end

  assign last = (left_c[PPW] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q      <= DIR_UPLOAD;
      busy_q     <= 1'b0;
      rdy_q      <= 1'b0;
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_lane_q  <= '0;
      x0_q       <= '0;
      y0_q       <= '0;
      w_q        <= '0;
      h_q        <= '0;
      col_q      <= '0;
      row_q      <= '0;
      left_q     <= '0;
    end else begin
      done_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_lane_q  <= '0;
      if (abort_i) begin
        busy_q <= 1'b0;
        rdy_q  <= 1'b0;
      end else if (start_i) begin
        dir_q  <= start_rd_i ? DIR_DOWNLOAD : DIR_UPLOAD;
        busy_q <= 1'b1;
        rdy_q  <= start_rd_i;
        x0_q   <= dec_x;
        y0_q   <= dec_y;
        w_q    <= dec_w;
        h_q    <= dec_h;
        col_q  <= '0;
        row_q  <= dec_y;
        left_q <= dec_h;
      end else if (fire) begin
        col_q  <= col_c[PPW];
        row_q  <= row_c[PPW];
        left_q <= left_c[PPW];
        if (dir_q == DIR_DOWNLOAD) begin
          rd_valid_q <= 1'b1;
          rd_lane_q  <= live;
        end
        if (last) begin
          busy_q <= 1'b0;
          rdy_q  <= 1'b0;
          done_q <= (dir_q == DIR_UPLOAD);
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign img_ready_o = rdy_q;
  assign rd_valid_o  = rd_valid_q;
  assign done_o      = done_q;
  assign done_x_o    = x0_q;
  assign done_y_o    = y0_q;
  assign done_w_o    = w_q;
  assign done_h_o    = h_q;

  // R8
  rdy_implies_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_ready_o |-> busy_o);
  // R8
  rd_data_after_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(img_ready_o));
  // R9
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10
  abort_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !img_ready_o && !done_o));
  // R7
  offset_in_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, col_q} < w_q));
endmodule

// File: tb/rect_xfer_engine_tb.sv
`timescale 1ns/1ps
module rect_xfer_engine_tb;
  localparam int AW = 19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort, start, start_rd, wr_valid, rd_req;
  logic [31:0] pos, size, wr_data;
  logic        rd_valid, busy, img_ready, done;
  logic [31:0] rd_data, mem_wdata, mem_rdata;
  logic [1:0]  mem_we;
  logic [37:0] mem_addr;
  logic [9:0]  done_x;
  logic [8:0]  done_y;
  logic [10:0] done_w;
  logic [9:0]  done_h;

  always #10 clk = ~clk;

  rect_xfer_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .start_i(start), .start_rd_i(start_rd),
    .pos_i(pos), .size_i(size), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .img_ready_o(img_ready), .done_o(done),
    .done_x_o(done_x), .done_y_o(done_y), .done_w_o(done_w), .done_h_o(done_h)
  );

  // pixel RAM environment
  logic [15:0] ram [int];
  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int a;
      a = int'(mem_addr[k*AW +: AW]);
      if (mem_we[k]) ram[a] = mem_wdata[k*16 +: 16];
      mem_rdata[k*16 +: 16] <= ram.exists(a) ? ram[a] : 16'h0;
    end
  end

  // reference model state
  int total = 0, bad = 0;
  string tag = "R11";
  logic [15:0] exp_mem [int];
  bit m_busy, m_rd, m_rdy, m_done, m_rdv;
  int m_x0, m_y0, m_w, m_h, m_row, m_off, m_left;
  logic [31:0] m_rdata;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit st, input bit srd, input logic [31:0] p, input logic [31:0] s,
                      input bit wv, input logic [31:0] wd, input bit rr, input bit ab);
    bit fire;
    int e_addr [2];
    bit e_live [2];
    int row, off, left;
    @(negedge clk);
    abort = ab; start = st; start_rd = srd; pos = p; size = s;
    wr_valid = wv; wr_data = wd; rd_req = rr;
    #1;
    chk(busy == m_busy, "busy", busy, m_busy);
    chk(img_ready == m_rdy, "img_ready", img_ready, m_rdy);
    chk(done == m_done, "done", done, m_done);
    if (m_done) begin
      chk(done_x == m_x0, "done_x", done_x, m_x0);
      chk(done_y == m_y0, "done_y", done_y, m_y0);
      chk(done_w == m_w, "done_w", done_w, m_w);
      chk(done_h == m_h, "done_h", done_h, m_h);
    end
    chk(rd_valid == m_rdv, "rd_valid", rd_valid, m_rdv);
    if (m_rdv) chk(rd_data == m_rdata, "rd_data", rd_data, m_rdata);

    fire = !ab && !st && m_busy && (m_rd ? rr : wv);
    row = m_row; off = m_off; left = m_left;
    for (int k = 0; k < 2; k++) begin
      e_live[k] = fire && (left > 0);
      e_addr[k] = row * 1024 + ((m_x0 + off) % 1024);
      if (e_live[k]) begin
        off++;
        if (off >= m_w) begin off = 0; row = (row + 1) % 512; left--; end
      end
    end
    for (int k = 0; k < 2; k++) begin
      bit ewe;
      ewe = e_live[k] && !m_rd;
      chk(mem_we[k] == ewe, "we", mem_we[k], ewe);
      if (ewe) begin
        chk(int'(mem_addr[k*AW +: AW]) == e_addr[k], "addr", mem_addr[k*AW +: AW], e_addr[k]);
        chk(mem_wdata[k*16 +: 16] == wd[k*16 +: 16], "wdata", mem_wdata[k*16 +: 16], wd[k*16 +: 16]);
      end
    end

    // advance model to the coming edge
    m_done = 0; m_rdv = 0;
    if (ab) begin
      m_busy = 0; m_rdy = 0;
    end else if (st) begin
      m_busy = 1; m_rd = srd; m_rdy = srd;
      m_x0 = int'(p & 32'h3ff);
      m_y0 = int'((p >> 16) & 32'h1ff);
      m_w  = int'(((s - 1) & 32'h3ff) + 1);
      m_h  = int'((((s >> 16) - 1) & 32'h1ff) + 1);
      m_row = m_y0; m_off = 0; m_left = m_h;
    end else if (fire) begin
      for (int k = 0; k < 2; k++) begin
        if (!m_rd && e_live[k]) exp_mem[e_addr[k]] = wd[k*16 +: 16];
        m_rdata[k*16 +: 16] = (e_live[k] && exp_mem.exists(e_addr[k])) ? exp_mem[e_addr[k]] : 16'h0;
      end
      m_row = row; m_off = off; m_left = left;
      m_rdv = m_rd;
      if (left == 0) begin
        m_busy = 0; m_rdy = 0; m_done = !m_rd;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic go(input bit rd, input int x, input int y, input int wf, input int hf);
    step(1, rd, (32'(y) << 16) | 32'(x), (32'(hf) << 16) | 32'(wf), 0, 0, 0, 0);
  endtask

  // n words of a running pattern, gap idle cycles after each word
  task automatic put(input int n, input int base, input int gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 1, {16'(base + 2*i + 1), 16'(base + 2*i)}, 0, 0);
      if (gap > 0) idle(gap > 1 ? 1 + (i % gap) : 1);
    end
  endtask

  task automatic get(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 0, 0, 0, 1, 0);
      if (gap > 0) idle(1 + (i % gap));
    end
  endtask

  initial begin
    abort = 0; start = 0; start_rd = 0; pos = 0; size = 0;
    wr_valid = 0; wr_data = 0; rd_req = 0;
    m_busy = 0; m_rd = 0; m_rdy = 0; m_done = 0; m_rdv = 0; m_rdata = 0;
    m_x0 = 0; m_y0 = 0; m_w = 0; m_h = 0; m_row = 0; m_off = 0; m_left = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    tag = "R11";                 // reset state, idle words ignored
    idle(2);
    put(3, 16'h0100, 0);
    get(2, 0);

    tag = "R1 R4";               // 3x2 at column 5 row 7
    go(0, 5, 7, 3, 2); put(3, 16'h1000, 0); idle(2);

    tag = "R6 R12";              // crosses column 1023, odd pixel count
    go(0, 1022, 3, 3, 1); put(2, 16'h2000, 0); idle(2);

    tag = "R5";                  // crosses row 511
    go(0, 100, 511, 2, 2); put(2, 16'h3000, 0); idle(2);

    tag = "R7";                  // width 5, gaps inside rows
    go(0, 20, 40, 5, 2); put(5, 16'h4000, 3); idle(2);

    tag = "R8";
    go(1, 20, 40, 5, 2); get(5, 2); idle(2);
    go(1, 5, 7, 3, 2); get(3, 0); idle(2);

    tag = "R8 R12";              // read back odd count and wrapped columns
    go(1, 1022, 3, 3, 1); get(2, 1); idle(2);

    tag = "R2";                  // width field 0 -> 1024
    go(0, 0, 100, 0, 1); put(512, 16'h5000, 0); idle(2);
    go(1, 0, 100, 0, 1); get(512, 0); idle(2);

    tag = "R3";                  // height field 0 -> 512, starts at row 300
    go(0, 7, 300, 1, 0); put(256, 16'h6000, 0); idle(2);

    tag = "R9";
    go(0, 900, 450, 1, 1); put(1, 16'h7000, 0); idle(2);

    tag = "R10";
    go(0, 60, 60, 4, 4); put(2, 16'h8000, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    put(3, 16'h8100, 0); idle(2);
    go(1, 60, 60, 4, 4); get(1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    get(2, 0); idle(2);
    tag = "R10 R11";             // written pixels survive, later words not written
    go(1, 60, 60, 4, 1); get(2, 0); idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog %s actual=timeout expected=finish", tag);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule